// File: doc/BRIEF.md
# Reselect Burst Controller for a Disconnecting Bus Target

This block runs on the target side of a host bus link that moves CAMAC data through a 16 KB transfer FIFO. When a command may disconnect, the block keeps the target off the host bus while the CAMAC side fills the FIFO (reads) or drains it (writes). It asks to reselect the host only once enough data, or enough free space, has built up for a useful burst. It then counts the burst down one host byte at a time and lets go of the bus again. When a command may not disconnect, the block holds the link for the whole transfer.

The host bus handshake is valid/ready. `resel_valid_o` stays high, and `burst_bytes_o` stays frozen, until `resel_ready_i` is seen high on a clock edge. This lets the arbitration logic hold the request back for as long as it needs to. The handshake carries no data. A burst is then moved as single-byte beats on `host_byte_i`, one per clock at most. The block does not model the FIFO itself, the CAMAC cycles, or the bus phases. It only watches `fifo_level_i`.

Top module: `resel_burst_ctl`

## Requirements
- R1: While reset is low, and after it is released until the first start, `resel_valid_o`, `connected_o` and `done_o` are 0 and `burst_bytes_o` is 0.
- R2: A start with `disc_priv_i`=1, `disc_dis_i`=0 and a valid burst code leaves the target disconnected. Any other combination makes `connected_o` high from the next cycle, with `burst_bytes_o` equal to the bytes still to move, and `resel_valid_o` never rises during that transfer.
- R3: For reads (`dir_rd_i`=1), while disconnected, `resel_valid_o` rises one cycle after `fifo_level_i` reaches the threshold.
- R4: For writes (`dir_rd_i`=0), the trigger is a free space of 16384 minus `fifo_level_i` reaching the threshold.
- R5: The threshold code `frac_sel_i` selects 2048 bytes for 00, 4096 for 01, and 8192 for both 10 and 11.
- R6: The burst code `burst_sel_i` selects 512 bytes for 11, 1024 for 10 and 2048 for 00. Code 01 is invalid and forces a continuous transfer.
- R7: When fewer bytes remain than the threshold, the trigger is the full remaining length being buffered (reads) or free (writes). The burst offered is the smaller of the burst size and the remaining length.
- R8: A request holds `resel_valid_o` and a stable `burst_bytes_o` until `resel_ready_i` is high on a clock edge. In the next cycle `connected_o` is 1 and `resel_valid_o` is 0.
- R9: While connected, each `host_byte_i` lowers `burst_bytes_o` by one. After the last byte of a burst, `connected_o` drops in the next cycle. If the transfer is complete, `done_o` pulses for exactly one cycle instead of a new wait.
- R10: `host_byte_i` while not connected changes no byte count, so later bursts still add up to the transfer length.
- R11: Direction, threshold code, burst code and length are latched at the start. A start while a transfer is active is ignored, as are later changes to these inputs.
- R12: A start with length 0 pulses `done_o` in the next cycle without connecting or requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a transfer (used only when idle) |
| dir_rd_i | input | 1 | 1 = CAMAC read (FIFO fills), 0 = write (FIFO drains) |
| xfer_len_i | input | LEN_W | Transfer length in bytes |
| frac_sel_i | input | 2 | Threshold fraction code |
| burst_sel_i | input | 2 | Burst size code |
| disc_priv_i | input | 1 | Disconnect privilege granted by the host |
| disc_dis_i | input | 1 | Per-command disconnect disable |
| fifo_level_i | input | LVL_W | Bytes currently held in the FIFO |
| host_byte_i | input | 1 | One byte moved on the host bus this cycle |
| resel_ready_i | input | 1 | Reselection granted |
| resel_valid_o | output | 1 | Reselection request |
| burst_bytes_o | output | LEN_W | Bytes left in the offered or running burst (or in the whole transfer when continuous) |
| connected_o | output | 1 | Target holds the host bus |
| done_o | output | 1 | One-cycle pulse when the last byte has moved |

## Verification
The assertions take for granted that `host_byte_i` means one byte per cycle, and that `fifo_level_i` never exceeds the FIFO size. They also assume the arbiter may delay `resel_ready_i` for any number of cycles. The stimulus keeps the level within 0 to 16384. It holds the grant back for several cycles before raising it, and pulses `host_byte_i` only at one byte per clock, including a few stray pulses while the target is parked, which must be ignored.

// File: rtl/resel_pkg.sv
package resel_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_STREAM,
    RS_PARK,
    RS_ASK,
    RS_BURST
  } rs_state_e;

  localparam int FRAC_CODES = 3;

endpackage

// File: rtl/resel_thresh.sv
module resel_thresh #(
  parameter int FIFO_BYTES = 16384,
  parameter int LEN_W      = 24,
  parameter int LVL_W      = $clog2(FIFO_BYTES) + 1
) (
  input  logic             dir_rd_i,
  input  logic [1:0]       frac_i,
  input  logic [LEN_W-1:0] rem_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             hit_o
);
  import resel_pkg::*;

  logic [LEN_W-1:0] thr_tab [FRAC_CODES];
  logic [LEN_W-1:0] thr;
  logic [LEN_W-1:0] need;
  logic [LEN_W-1:0] avail;

  // entry k holds FIFO_BYTES >> (3-k): 1/8, 1/4, 1/2
  for (genvar k = 0; k < FRAC_CODES; k++) begin : g_thr
    assign thr_tab[k] = LEN_W'(FIFO_BYTES >> (FRAC_CODES - k));
  end

  always_comb begin
    case (frac_i)
      2'b00:   thr = thr_tab[0];
      2'b01:   thr = thr_tab[1];
      default: thr = thr_tab[2];
    endcase
    need  = (rem_i < thr) ? rem_i : thr;
    avail = dir_rd_i ? LEN_W'(level_i)
                     : LEN_W'(FIFO_BYTES) - LEN_W'(level_i);
    hit_o = (rem_i != '0) && (avail >= need);
  end

endmodule

// File: rtl/resel_burst_dec.sv
module resel_burst_dec #(
  parameter int LEN_W      = 24,
  parameter int BURST_UNIT = 512
) (
  input  logic [1:0]       code_i,
  output logic [LEN_W-1:0] size_o,
  output logic             ok_o
);
  always_comb begin
    ok_o = 1'b1;
    case (code_i)
      2'b11:   size_o = LEN_W'(BURST_UNIT);
      2'b10:   size_o = LEN_W'(2 * BURST_UNIT);
      2'b00:   size_o = LEN_W'(4 * BURST_UNIT);
      default: begin
        size_o = '0;
        ok_o   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/resel_down_ctr.sv
module resel_down_ctr #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_o <= '0;
    else if (load_i)                cnt_o <= val_i;
    else if (dec_i && cnt_o != '0)  cnt_o <= cnt_o - W'(1);
  end

endmodule

// File: rtl/resel_burst_ctl.sv
module resel_burst_ctl #(
  parameter int FIFO_BYTES = 16384,
  parameter int LEN_W      = 24,
  parameter int BURST_UNIT = 512,
  parameter int LVL_W      = $clog2(FIFO_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dir_rd_i,
  input  logic [LEN_W-1:0] xfer_len_i,
  input  logic [1:0]       frac_sel_i,
  input  logic [1:0]       burst_sel_i,
  input  logic             disc_priv_i,
  input  logic             disc_dis_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic             host_byte_i,
  input  logic             resel_ready_i,
  output logic             resel_valid_o,
  output logic [LEN_W-1:0] burst_bytes_o,
  output logic             connected_o,
  output logic             done_o
);
  import resel_pkg::*;

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  rs_state_e        state_q, state_d;
  logic             dir_q;
  logic [1:0]       frac_q;
  logic [LEN_W-1:0] bsize_q;
  logic [LEN_W-1:0] rem;
  logic [LEN_W-1:0] bcnt;
  logic [LEN_W-1:0] bsize_new;
  logic             bcode_ok;
  logic             hit;
  logic             rem_load, rem_dec, b_load, b_dec, done_d;
  logic             accept;
  logic             disc_ok;
  logic [LEN_W-1:0] b_first;

  resel_burst_dec #(.LEN_W(LEN_W), .BURST_UNIT(BURST_UNIT)) u_dec (
    .code_i (burst_sel_i),
    .size_o (bsize_new),
    .ok_o   (bcode_ok)
  );

  resel_thresh #(.FIFO_BYTES(FIFO_BYTES), .LEN_W(LEN_W), .LVL_W(LVL_W)) u_thr (
    .dir_rd_i (dir_q),
    .frac_i   (frac_q),
    .rem_i    (rem),
    .level_i  (fifo_level_i),
    .hit_o    (hit)
  );

  resel_down_ctr #(.W(LEN_W)) u_rem (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (rem_load),
    .val_i  (xfer_len_i),
    .dec_i  (rem_dec),
    .cnt_o  (rem)
  );

  resel_down_ctr #(.W(LEN_W)) u_bcnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (b_load),
    .val_i  (b_first),
    .dec_i  (b_dec),
    .cnt_o  (bcnt)
  );

  assign accept  = (state_q == RS_IDLE) && start_i;
  assign disc_ok = disc_priv_i && !disc_dis_i && bcode_ok;
  assign b_first = (bsize_q < rem) ? bsize_q : rem;

  always_comb begin
    state_d  = state_q;
    rem_load = 1'b0;
    rem_dec  = 1'b0;
    b_load   = 1'b0;
    b_dec    = 1'b0;
    done_d   = 1'b0;
    case (state_q)
      RS_IDLE: begin
        if (start_i) begin
          if (xfer_len_i == '0) begin
            done_d = 1'b1;
          end else begin
            rem_load = 1'b1;
            state_d  = disc_ok ? RS_PARK : RS_STREAM;
          end
        end
      end
      RS_STREAM: begin
        if (host_byte_i) begin
          rem_dec = 1'b1;
          if (rem == ONE) begin
            state_d = RS_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      RS_PARK: begin
        if (hit) begin
          b_load  = 1'b1;
          state_d = RS_ASK;
        end
      end
      RS_ASK: begin
        if (resel_ready_i) state_d = RS_BURST;
      end
      RS_BURST: begin
        if (host_byte_i) begin
          rem_dec = 1'b1;
          b_dec   = 1'b1;
          if (bcnt == ONE) begin
            if (rem == ONE) begin
              state_d = RS_IDLE;
              done_d  = 1'b1;
            end else begin
              state_d = RS_PARK;
            end
          end
        end
      end
      default: state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      done_o  <= 1'b0;
      dir_q   <= 1'b0;
      frac_q  <= 2'b00;
      bsize_q <= '0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      if (accept) begin
        dir_q   <= dir_rd_i;
        frac_q  <= frac_sel_i;
        bsize_q <= bsize_new;
      end
    end
  end

  assign resel_valid_o = (state_q == RS_ASK);
  assign connected_o   = (state_q == RS_STREAM) || (state_q == RS_BURST);

  always_comb begin
    case (state_q)
      RS_STREAM:        burst_bytes_o = rem;
      RS_ASK, RS_BURST: burst_bytes_o = bcnt;
      default:          burst_bytes_o = '0;
    endcase
  end

endmodule

// File: rtl/resel_burst_ctl_chk.sv
module resel_burst_ctl_chk #(
  parameter int LEN_W     = 24,
  parameter int MAX_BURST = 2048
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_byte_i,
  input logic             resel_ready_i,
  input logic             resel_valid_o,
  input logic [LEN_W-1:0] burst_bytes_o,
  input logic             connected_o,
  input logic             done_o
);
  // R8: request held with a frozen burst size until granted
  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    resel_valid_o && !resel_ready_i |=> resel_valid_o && $stable(burst_bytes_o));

  // R8: a grant moves the target onto the bus
  a_r8_grant_connects: assert property (@(posedge clk) disable iff (!rst_n)
    resel_valid_o && resel_ready_i |=> connected_o && !resel_valid_o);

  // R2: never asking for the bus while already holding it
  a_r2_no_ask_when_connected: assert property (@(posedge clk) disable iff (!rst_n)
    !(resel_valid_o && connected_o));

  // R9: completion is a single-cycle pulse
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: each host byte during a connection lowers the count by one
  a_r9_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    connected_o && host_byte_i && burst_bytes_o > LEN_W'(1)
      |=> connected_o && burst_bytes_o == $past(burst_bytes_o) - LEN_W'(1));

  // R7: an offered burst is non-empty and no larger than the biggest size
  a_r7_burst_range: assert property (@(posedge clk) disable iff (!rst_n)
    resel_valid_o |-> burst_bytes_o != '0 && burst_bytes_o <= LEN_W'(MAX_BURST));

endmodule

bind resel_burst_ctl resel_burst_ctl_chk #(
  .LEN_W     (LEN_W),
  .MAX_BURST (4 * BURST_UNIT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_byte_i   (host_byte_i),
  .resel_ready_i (resel_ready_i),
  .resel_valid_o (resel_valid_o),
  .burst_bytes_o (burst_bytes_o),
  .connected_o   (connected_o),
  .done_o        (done_o)
);

// File: tb/resel_burst_ctl_test.sv
`timescale 1ns/1ps
module resel_burst_ctl_test;

  localparam int LEN_W = 24;
  localparam int LVL_W = 15;
  localparam int FULL  = 16384;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             dir_rd_i = 1'b0;
  logic [LEN_W-1:0] xfer_len_i = '0;
  logic [1:0]       frac_sel_i = 2'b00;
  logic [1:0]       burst_sel_i = 2'b00;
  logic             disc_priv_i = 1'b0;
  logic             disc_dis_i = 1'b0;
  logic [LVL_W-1:0] fifo_level_i = '0;
  logic             host_byte_i = 1'b0;
  logic             resel_ready_i = 1'b0;
  logic             resel_valid_o;
  logic [LEN_W-1:0] burst_bytes_o;
  logic             connected_o;
  logic             done_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  resel_burst_ctl uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_rd_i(dir_rd_i),
    .xfer_len_i(xfer_len_i), .frac_sel_i(frac_sel_i), .burst_sel_i(burst_sel_i),
    .disc_priv_i(disc_priv_i), .disc_dis_i(disc_dis_i), .fifo_level_i(fifo_level_i),
    .host_byte_i(host_byte_i), .resel_ready_i(resel_ready_i),
    .resel_valid_o(resel_valid_o), .burst_bytes_o(burst_bytes_o),
    .connected_o(connected_o), .done_o(done_o)
  );

  // ---------------- behavioural reference ----------------
  // modes: 0 idle, 1 continuous, 2 parked, 3 asking, 4 bursting
  int m_mode = 0, m_left = 0, m_burst = 0, m_dir = 0, m_frac = 0, m_size = 0;
  bit m_done = 1'b0;

  function automatic int size_of(int code);
    case (code)
      3: return 512;
      2: return 1024;
      0: return 2048;
      default: return 0;
    endcase
  endfunction

  function automatic bit ready_to_ask(int left, int dir, int frac, int level);
    int th, want, room;
    th   = (frac == 0) ? FULL / 8 : (frac == 1) ? FULL / 4 : FULL / 2;
    want = (left < th) ? left : th;
    room = (dir != 0) ? level : FULL - level;
    return (left > 0) && (room >= want);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_burst = 0; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      case (m_mode)
        0: if (start_i) begin
             if (xfer_len_i == 0) m_done = 1'b1;
             else begin
               m_left = int'(xfer_len_i);
               m_dir  = int'(dir_rd_i);
               m_frac = int'(frac_sel_i);
               m_size = size_of(int'(burst_sel_i));
               m_mode = (disc_priv_i && !disc_dis_i && m_size != 0) ? 2 : 1;
             end
           end
        1: if (host_byte_i) begin
             m_left--;
             if (m_left == 0) begin m_mode = 0; m_done = 1'b1; end
           end
        2: if (ready_to_ask(m_left, m_dir, m_frac, int'(fifo_level_i))) begin
             m_burst = (m_size < m_left) ? m_size : m_left;
             m_mode  = 3;
           end
        3: if (resel_ready_i) m_mode = 4;
        default: if (host_byte_i) begin
             m_left--; m_burst--;
             if (m_burst == 0) begin
               if (m_left == 0) begin m_mode = 0; m_done = 1'b1; end
               else m_mode = 2;
             end
           end
      endcase
    end
  end

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare against the reference every clock, away from the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      check("R3 request vs model",   int'(resel_valid_o), int'(m_mode == 3));
      check("R2 connected vs model", int'(connected_o),   int'(m_mode == 1 || m_mode == 4));
      check("R9 done vs model",      int'(done_o),        int'(m_done));
      check("R7 burst vs model",     int'(burst_bytes_o),
            (m_mode == 1) ? m_left : (m_mode == 3 || m_mode == 4) ? m_burst : 0);
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_xfer(bit rd, int len, logic [1:0] fr, logic [1:0] bs, bit pv, bit ds);
    dir_rd_i = rd; xfer_len_i = LEN_W'(len); frac_sel_i = fr;
    burst_sel_i = bs; disc_priv_i = pv; disc_dis_i = ds; start_i = 1'b1;
    cyc(1);
    start_i = 1'b0;
  endtask

  task automatic expect_out(string tag, bit v, int b, bit c);
    check({tag, " valid"}, int'(resel_valid_o), int'(v));
    check({tag, " burst"}, int'(burst_bytes_o), b);
    check({tag, " conn"},  int'(connected_o),   int'(c));
  endtask

  task automatic drain(bit rd, string tag);
    bit saw = 1'b0;
    fifo_level_i = rd ? LVL_W'(FULL) : '0;
    for (int i = 0; i < 60000 && !saw; i++) begin
      resel_ready_i = resel_valid_o;
      host_byte_i   = connected_o;
      cyc(1);
      if (done_o) saw = 1'b1;
    end
    host_byte_i = 1'b0; resel_ready_i = 1'b0;
    check({tag, " transfer completes"}, int'(saw), 1);
    cyc(1);
  endtask

  initial begin
    // R1: reset state
    cyc(2);
    expect_out("R1 in reset", 1'b0, 0, 1'b0);
    rst_n = 1'b1;
    cyc(2);
    expect_out("R1 after reset", 1'b0, 0, 1'b0);
    check("R1 done after reset", int'(done_o), 0);

    // read, 1/8 threshold, 2048-byte bursts
    begin_xfer(1'b1, 3000, 2'b00, 2'b00, 1'b1, 1'b0);
    expect_out("R2 parked after start", 1'b0, 0, 1'b0);
    host_byte_i = 1'b1;                      // R10: stray bytes while parked
    cyc(3);
    host_byte_i = 1'b0;
    fifo_level_i = 2047;
    start_i = 1'b1; xfer_len_i = 7;          // R11: ignored second start
    burst_sel_i = 2'b11; frac_sel_i = 2'b10; // R11: ignored config change
    cyc(1);
    start_i = 1'b0;
    expect_out("R3 below threshold", 1'b0, 0, 1'b0);
    fifo_level_i = 2048;
    cyc(1);
    expect_out("R3 R11 at threshold", 1'b1, 2048, 1'b0);
    cyc(2);
    expect_out("R8 held without grant", 1'b1, 2048, 1'b0);
    resel_ready_i = 1'b1;
    cyc(1);
    resel_ready_i = 1'b0;
    expect_out("R8 connected after grant", 1'b0, 2048, 1'b1);
    host_byte_i = 1'b1;
    cyc(2047);
    expect_out("R9 last byte pending", 1'b0, 1, 1'b1);
    cyc(1);
    host_byte_i = 1'b0;
    expect_out("R9 released after burst", 1'b0, 0, 1'b0);
    check("R9 no done mid transfer", int'(done_o), 0);
    fifo_level_i = 951;
    cyc(1);
    expect_out("R7 short tail not buffered", 1'b0, 0, 1'b0);
    fifo_level_i = 952;
    cyc(1);
    expect_out("R7 R10 tail offered", 1'b1, 952, 1'b0);
    drain(1'b1, "R9 read");

    // R4: write, 1/4 threshold above the remaining length, 1024 bursts
    begin_xfer(1'b0, 2000, 2'b01, 2'b10, 1'b1, 1'b0);
    fifo_level_i = 15000;
    cyc(2);
    expect_out("R4 too little free space", 1'b0, 0, 1'b0);
    fifo_level_i = 14384;
    cyc(1);
    expect_out("R4 R6 free space reached", 1'b1, 1024, 1'b0);
    drain(1'b0, "R4 write");

    // R5: threshold codes 10, 11 and 01 on reads
    begin_xfer(1'b1, 20000, 2'b10, 2'b11, 1'b1, 1'b0);
    fifo_level_i = 8191;
    cyc(2);
    expect_out("R5 half minus one", 1'b0, 0, 1'b0);
    fifo_level_i = 8192;
    cyc(1);
    expect_out("R5 R6 half reached, 512 burst", 1'b1, 512, 1'b0);
    drain(1'b1, "R5 code 10");

    begin_xfer(1'b1, 9000, 2'b11, 2'b00, 1'b1, 1'b0);
    fifo_level_i = 8191;
    cyc(2);
    expect_out("R5 code 11 below", 1'b0, 0, 1'b0);
    fifo_level_i = 8192;
    cyc(1);
    expect_out("R5 code 11 reached", 1'b1, 2048, 1'b0);
    drain(1'b1, "R5 code 11");

    begin_xfer(1'b1, 10000, 2'b01, 2'b00, 1'b1, 1'b0);
    fifo_level_i = 4095;
    cyc(2);
    expect_out("R5 code 01 below", 1'b0, 0, 1'b0);
    fifo_level_i = 4096;
    cyc(1);
    expect_out("R5 code 01 reached", 1'b1, 2048, 1'b0);
    drain(1'b1, "R5 code 01");

    // R2: continuous transfers
    fifo_level_i = 0;
    begin_xfer(1'b1, 100, 2'b00, 2'b00, 1'b0, 1'b0);
    expect_out("R2 no privilege", 1'b0, 100, 1'b1);
    host_byte_i = 1'b1;
    cyc(40);
    host_byte_i = 1'b0;
    expect_out("R2 continuous count", 1'b0, 60, 1'b1);
    drain(1'b1, "R2 no privilege");

    begin_xfer(1'b0, 50, 2'b00, 2'b00, 1'b1, 1'b1);
    expect_out("R2 disconnect disabled", 1'b0, 50, 1'b1);
    drain(1'b0, "R2 disabled");

    begin_xfer(1'b1, 70, 2'b00, 2'b01, 1'b1, 1'b0);
    expect_out("R6 invalid burst code", 1'b0, 70, 1'b1);
    drain(1'b1, "R6 invalid");

    // R12: zero length
    begin_xfer(1'b1, 0, 2'b00, 2'b00, 1'b1, 1'b0);
    check("R12 done pulse", int'(done_o), 1);
    expect_out("R12 no connection", 1'b0, 0, 1'b0);
    cyc(1);
    check("R12 pulse ends", int'(done_o), 0);

    cyc(2);
    summary();
  end

endmodule